// File: doc/BRIEF.md
# Kernel Cache Invalidate and Writeback Tracker

This block keeps count of the cache invalidate and writeback requests that are still in flight for one kernel. Each count is held in a signed register. The request issuer adds a positive amount when it sends requests, and the acknowledgement path adds a negative amount when replies come back. Each side may apply one update per cycle.

The invalidate count has a distinct value of -1, which means invalidation has not begun for the kernel. Because of this, "started" and "done" are decoded as two separate status flags. A force input moves the invalidate count straight to zero, the finished state.

The writeback count starts at zero. Zero means either that no flush has begun or that the flush has completed. An update that would push either count out of its legal range is refused, and a sticky error flag is set. A kernel-reset input puts everything back to its starting state.

Top module: `inv_wb_tracker`

## Requirements
- R1: After rst_n is released, inv_count is -1, wb_count is 0, inv_started is 0, inv_done is 0, wb_done is 1 and err is 0.
- R2: inv_started is 1 exactly when inv_count differs from -1.
- R3: inv_done is 1 exactly when inv_count equals 0, so it is 0 while the count is still -1.
- R4: When inv_upd_vld is 1, inv_upd_val is read as a two's-complement signed value. If the sum is legal, it is added to inv_count, and the new value is visible after the next rising clock edge.
- R5: When wb_upd_vld is 1, wb_upd_val is read as a two's-complement signed value. If the sum is legal, it is added to wb_count on the next rising clock edge.
- R6: inv_force_done sets inv_count to 0 on the next edge. Any invalidate update in the same cycle is discarded.
- R7: An update is illegal if its sum is below 0 or above 2^(W-1)-1. This rule applies to both counts and includes an update of 0 applied while inv_count is -1. After an illegal update the count keeps its old value and err becomes 1. err then stays 1 until kern_rst.
- R8: kern_rst takes priority over every other input. On the next edge it returns inv_count to -1, wb_count to 0 and err to 0.
- R9: wb_done is 1 exactly when wb_count equals 0.
- R10: An update strobe held at 0 leaves its count unchanged, whatever value is on the matching value input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| kern_rst | input | 1 | Synchronous return to the starting state for a new kernel |
| inv_upd_vld | input | 1 | Invalidate update strobe |
| inv_upd_val | input | W | Signed change to the invalidate count |
| inv_force_done | input | 1 | Force the invalidate count to zero |
| wb_upd_vld | input | 1 | Writeback update strobe |
| wb_upd_val | input | W | Signed change to the writeback count |
| inv_count | output | W | Current invalidate count (signed) |
| wb_count | output | W | Current writeback count (signed) |
| inv_started | output | 1 | Invalidation has begun |
| inv_done | output | 1 | No invalidates pending and invalidation has begun |
| wb_done | output | 1 | No writebacks pending |
| err | output | 1 | Sticky flag for a refused update |

## Verification
The assertions assume that rst_n starts low. Apart from that they assume nothing about the inputs: illegal, colliding and forced updates are all legal stimulus, and the properties are built to cover them. The random stimulus draws update amounts mostly from a small signed window centred near zero, so the counts move around inside their range. It also injects occasional large amounts, forced completions and kernel resets, so that both the refusal path and the sentinel path are reached often.

// File: rtl/inv_wb_tracker_pkg.sv
package inv_wb_tracker_pkg;
   // Selects the starting value of a tracking counter.
   typedef enum logic {
      START_ZERO     = 1'b0,
      START_SENTINEL = 1'b1
   } start_kind_e;
endpackage

// File: rtl/trk_counter.sv
module trk_counter
   import inv_wb_tracker_pkg::*;
#(
   parameter int          W    = 8,
   parameter start_kind_e KIND = START_ZERO
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clr,
   input  logic                upd_vld,
   input  logic signed [W-1:0] upd_val,
   input  logic                force_zero,
   output logic signed [W-1:0] count,
   output logic                illegal
);
   localparam logic signed [W:0] MAXV = (W+1)'((1 << (W-1)) - 1);

   initial begin
      if (W < 2) $error("trk_counter: W must be at least 2");
   end

   logic signed [W-1:0] start_val;
   logic signed [W:0]   sum;

   generate
      if (KIND == START_SENTINEL) begin : g_sentinel
         assign start_val = '1;
      end else begin : g_zero
         assign start_val = '0;
      end
   endgenerate

   // Sum is one bit wider than the count, so no legal pair of operands can wrap.
   assign sum     = {count[W-1], count} + {upd_val[W-1], upd_val};
   assign illegal = upd_vld && !force_zero && ((sum < 0) || (sum > MAXV));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          count <= start_val;
      else if (clr)        count <= start_val;
      else if (force_zero) count <= '0;
      else if (upd_vld && !illegal) count <= sum[W-1:0];
   end

   assert_hold_on_illegal_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (illegal && !clr) |=> $stable(count));
   assert_force_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (force_zero && !clr) |=> (count == '0));
   assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (count == start_val));
   assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !force_zero && !upd_vld) |=> $stable(count));
   assert_floor_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (count >= start_val));
endmodule

// File: rtl/trk_err_latch.sv
module trk_err_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic set_a,
   input  logic set_b,
   output logic err
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              err <= 1'b0;
      else if (clr)            err <= 1'b0;
      else if (set_a || set_b) err <= 1'b1;
   end

   assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (err && !clr) |=> err);
   assert_err_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ((set_a || set_b) && !clr) |=> err);
   assert_err_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !err);
endmodule

// File: rtl/inv_wb_tracker.sv
module inv_wb_tracker
   import inv_wb_tracker_pkg::*;
#(
   parameter int W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                kern_rst,
   input  logic                inv_upd_vld,
   input  logic signed [W-1:0] inv_upd_val,
   input  logic                inv_force_done,
   input  logic                wb_upd_vld,
   input  logic signed [W-1:0] wb_upd_val,
   output logic signed [W-1:0] inv_count,
   output logic signed [W-1:0] wb_count,
   output logic                inv_started,
   output logic                inv_done,
   output logic                wb_done,
   output logic                err
);
   logic inv_bad;
   logic wb_bad;

   trk_counter #(.W(W), .KIND(START_SENTINEL)) u_inv (
      .clk(clk), .rst_n(rst_n), .clr(kern_rst),
      .upd_vld(inv_upd_vld), .upd_val(inv_upd_val),
      .force_zero(inv_force_done),
      .count(inv_count), .illegal(inv_bad));

   trk_counter #(.W(W), .KIND(START_ZERO)) u_wb (
      .clk(clk), .rst_n(rst_n), .clr(kern_rst),
      .upd_vld(wb_upd_vld), .upd_val(wb_upd_val),
      .force_zero(1'b0),
      .count(wb_count), .illegal(wb_bad));

   trk_err_latch u_err (
      .clk(clk), .rst_n(rst_n), .clr(kern_rst),
      .set_a(inv_bad), .set_b(wb_bad), .err(err));

   assign inv_started = (inv_count != '1);
   assign inv_done    = (inv_count == '0);
   assign wb_done     = (wb_count == '0);

   assert_done_needs_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
      inv_done |-> inv_started);
   assert_wb_nonneg_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !wb_count[W-1]);
endmodule

// File: tb/inv_wb_tracker_tb_top.sv
module inv_wb_tracker_tb_top;
   localparam int W    = 8;
   localparam int MAXV = 127;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic kern_rst = 1'b0;
   logic inv_upd_vld = 1'b0;
   logic inv_force_done = 1'b0;
   logic wb_upd_vld = 1'b0;
   logic signed [W-1:0] inv_upd_val = '0;
   logic signed [W-1:0] wb_upd_val = '0;
   logic signed [W-1:0] inv_count, wb_count;
   logic inv_started, inv_done, wb_done, err;

   int checks = 0;
   int failures = 0;
   int m_inv, m_wb;
   bit m_err;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   inv_wb_tracker #(.W(W)) dut_i (
      .clk(clk), .rst_n(rst_n), .kern_rst(kern_rst),
      .inv_upd_vld(inv_upd_vld), .inv_upd_val(inv_upd_val),
      .inv_force_done(inv_force_done),
      .wb_upd_vld(wb_upd_vld), .wb_upd_val(wb_upd_val),
      .inv_count(inv_count), .wb_count(wb_count),
      .inv_started(inv_started), .inv_done(inv_done),
      .wb_done(wb_done), .err(err));

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic bit out_of_range(input int s);
      return (s < 0) || (s > MAXV);
   endfunction

   // Expected next state, derived from R4..R8 and R10.
   task automatic model(input bit kr, input bit iv_v, input int iv, input bit fd,
                        input bit wb_v, input int wv);
      int s;
      if (kr) begin
         m_inv = -1; m_wb = 0; m_err = 1'b0;
      end else begin
         if (fd) m_inv = 0;
         else if (iv_v) begin
            s = m_inv + iv;
            if (out_of_range(s)) m_err = 1'b1; else m_inv = s;
         end
         if (wb_v) begin
            s = m_wb + wv;
            if (out_of_range(s)) m_err = 1'b1; else m_wb = s;
         end
      end
   endtask

   task automatic check_all(input string ctx);
      chk({ctx, " R4 inv_count"}, int'(inv_count), m_inv);
      chk({ctx, " R5 wb_count"}, int'(wb_count), m_wb);
      chk({ctx, " R2 inv_started"}, int'(inv_started), int'(m_inv != -1));
      chk({ctx, " R3 inv_done"}, int'(inv_done), int'(m_inv == 0));
      chk({ctx, " R9 wb_done"}, int'(wb_done), int'(m_wb == 0));
      chk({ctx, " R7 err"}, int'(err), int'(m_err));
   endtask

   task automatic step(input string ctx, input bit kr, input bit iv_v, input int iv,
                       input bit fd, input bit wb_v, input int wv);
      @(negedge clk);
      kern_rst = kr; inv_upd_vld = iv_v; inv_upd_val = W'(iv);
      inv_force_done = fd; wb_upd_vld = wb_v; wb_upd_val = W'(wv);
      @(posedge clk);
      model(kr, iv_v, iv, fd, wb_v, wv);
      @(negedge clk);
      kern_rst = 1'b0; inv_upd_vld = 1'b0; inv_force_done = 1'b0; wb_upd_vld = 1'b0;
      check_all(ctx);
   endtask

   initial begin
      #(4 * 200000);
      if (!finished) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      int unused_seed;
      unused_seed = $urandom(32'h5eed_1234);
      m_inv = -1; m_wb = 0; m_err = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset inv_count", int'(inv_count), -1);
      chk("R1 reset wb_count", int'(wb_count), 0);
      chk("R1 reset inv_started", int'(inv_started), 0);
      chk("R1 reset inv_done", int'(inv_done), 0);
      chk("R1 reset wb_done", int'(wb_done), 1);
      chk("R1 reset err", int'(err), 0);

      step("R10 idle with values", 0, 0, 5, 0, 0, 7);
      step("R2 start by +1", 0, 1, 1, 0, 0, 0);
      step("R4 issue 3", 0, 1, 3, 0, 1, 4);
      step("R4 drain 3", 0, 1, -3, 0, 1, -2);
      step("R7 inv below zero", 0, 1, -1, 0, 0, 0);
      step("R7 err stays", 0, 1, 2, 0, 0, 0);
      step("R7 wb below zero", 0, 0, 0, 0, 1, -3);
      step("R8 kernel reset", 1, 1, 9, 1, 1, 9);
      chk("R8 inv_count back to sentinel", int'(inv_count), -1);
      step("R7 zero update on sentinel", 0, 1, 0, 0, 0, 0);
      step("R8 clear err", 1, 0, 0, 0, 0, 0);
      step("R6 force beats update", 0, 1, 5, 1, 0, 0);
      chk("R6 forced to zero", int'(inv_count), 0);
      step("R4 to max", 0, 1, 127, 0, 1, 127);
      step("R7 above max", 0, 1, 1, 0, 1, 1);
      step("R10 idle after overflow", 0, 0, -100, 0, 0, -100);
      step("R8 reset again", 1, 0, 0, 0, 0, 0);

      for (int i = 0; i < 3000; i++) begin
         bit kr, ivv, fd, wbv;
         int iv, wv;
         kr  = ($urandom % 100) < 2;
         fd  = ($urandom % 100) < 4;
         ivv = ($urandom % 100) < 70;
         wbv = ($urandom % 100) < 70;
         iv  = (($urandom % 100) < 3) ? int'($urandom % 256) - 128 : int'($urandom % 11) - 4;
         wv  = (($urandom % 100) < 3) ? int'($urandom % 256) - 128 : int'($urandom % 11) - 4;
         step("rand", kr, ivv, iv, fd, wbv, wv);
      end

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule